// File: doc/BRIEF.md
# Pipelined Merge-Exchange Key Sorter

This block sorts a fixed-size vector of unsigned keys into ascending order. Every compare/exchange position is produced while the design elaborates, by walking the merge-exchange schedule loops. Those loops carry a block size `p`, a running bound `q`, a residue `r` and a distance `d`. At each logic level, every index `i` with `i + d < N` and `(i & p) == r` is paired with index `i + d`. The pair receives one compare/exchange operation, which puts the smaller key at `i` and the larger key at `i + d`.

A register bank follows every logic level. The critical path is therefore one comparator plus its multiplexers, and the sorter takes a new vector on every clock. The input valid flag travels through a shift register that has one stage per level, so each result leaves with its own valid strobe. A caller packs N keys onto one flat bus, raises `in_valid`, and collects the sorted vector a fixed number of cycles later. The size N must be a power of two and defaults to 16. The key width is a parameter.

Top module: `msort_net`

## Requirements
- R1: When `out_valid` is high, the output keys are in non-decreasing unsigned order. Element k sits at bits `[k*KW +: KW]`, and element 0 holds the smallest key.
- R2: Each output vector is a permutation of the input vector accepted L cycles earlier, so the multiset of keys is preserved.
- R3: The latency is exactly L = log2N·(log2N+1)/2 clock cycles (10 for N=16). `out_valid` equals `in_valid` from L cycles before.
- R4: A new vector is accepted on every clock. Back-to-back valid vectors each come out sorted in consecutive cycles, in their input order.
- R5: A synchronous active-high `rst` clears every valid stage. `out_valid` is low in the cycle after reset. Vectors in flight, and the vector presented during reset, never appear as valid.
- R6: Equal keys are treated as in order and are never disturbed. A vector whose keys are all equal comes out unchanged.
- R7: Keys compare as unsigned values. A key with its MSB set sorts above every key with the MSB clear, and all-ones sorts last.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low exactly L cycles later. The bubble does not disturb the neighbouring valid results.
- R9: Vectors that are already sorted pass through unchanged. Fully reversed vectors come out fully ascending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_keys` as a vector to sort this cycle |
| in_keys | input | N*KW | Unsorted keys, element k at bits `[k*KW +: KW]` |
| out_valid | output | 1 | Marks `out_keys` as a sorted result |
| out_keys | output | N*KW | Sorted keys, element 0 smallest |

## Verification
Two functions can fall in the same cycle: a synchronous reset and a pipeline already full of valid vectors. The bench raises `rst` for one cycle in the middle of a back-to-back random stream. It expects the L vectors in flight, and the vector presented during reset, to come out with `out_valid` low. The vectors accepted after the reset must still come out sorted on schedule. Results are judged against a bench reference sort of each captured input, using a record indexed by input cycle.

// File: rtl/msort_pkg.sv
package msort_pkg;

    typedef struct packed {
        int unsigned p;
        int unsigned r;
        int unsigned d;
    } lvl_sched_t;

    function automatic int unsigned num_levels(input int unsigned n);
        int unsigned lg;
        lg = $clog2(n);
        return (lg * (lg + 1)) / 2;
    endfunction

    // Walk the merge-exchange loops and return (p, r, d) of level 'lvl'.
    function automatic lvl_sched_t level_sched(input int unsigned n, input int unsigned lvl);
        int unsigned t, p, q, r, d, qs, cnt;
        lvl_sched_t res;
        t   = $clog2(n);
        p   = 1 << (t - 1);
        cnt = 0;
        res = '0;
        while (p > 0) begin
            q = 1 << (t - 1);
            r = 0;
            d = p;
            do begin
                if (cnt == lvl) begin
                    res.p = p;
                    res.r = r;
                    res.d = d;
                end
                cnt = cnt + 1;
                qs  = q;
                d   = q - p;
                q   = q / 2;
                r   = p;
            end while (qs != p);
            p = p / 2;
        end
        return res;
    endfunction

endpackage

// File: rtl/msort_level.sv
module msort_level #(
    parameter int unsigned N  = 16,
    parameter int unsigned KW = 8,
    parameter int unsigned P  = 1,
    parameter int unsigned R  = 0,
    parameter int unsigned D  = 1
) (
    input  logic                   clk,
    input  logic [N-1:0][KW-1:0]   keys_i,
    output logic [N-1:0][KW-1:0]   keys_o
);

    logic [N-1:0][KW-1:0] keys_d;
    logic [N-1:0][KW-1:0] keys_q;

    // Compare/exchange on every scheduled pair; untouched lanes pass through.
    always_comb begin
        keys_d = keys_i;
        for (int unsigned i = 0; i < N; i++) begin
            if ((i + D < N) && ((i & P) == R)) begin
                if (keys_i[i] > keys_i[i + D]) begin
                    keys_d[i]     = keys_i[i + D];
                    keys_d[i + D] = keys_i[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        keys_q <= keys_d;
    end

    assign keys_o = keys_q;

endmodule

// File: rtl/msort_vpipe.sv
module msort_vpipe #(
    parameter int unsigned DEPTH = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic vin,
    output logic vout
);

    logic [DEPTH-1:0] vld_d;
    logic [DEPTH-1:0] vld_q;

    always_comb begin
        vld_d[0] = vin;
        for (int unsigned k = 1; k < DEPTH; k++) begin
            vld_d[k] = vld_q[k - 1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= vld_d;
    end

    assign vout = vld_q[DEPTH-1];

endmodule

// File: rtl/msort_net.sv
module msort_net #(
    parameter int unsigned N  = 16,
    parameter int unsigned KW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [N*KW-1:0] in_keys,
    output logic            out_valid,
    output logic [N*KW-1:0] out_keys
);
    import msort_pkg::*;

    localparam int unsigned L = num_levels(N);

    logic [N-1:0][KW-1:0] stage_keys [0:L];

    assign stage_keys[0] = in_keys;

    for (genvar g = 0; g < L; g++) begin : g_lvl
        localparam lvl_sched_t S = level_sched(N, g);
        msort_level #(
            .N  (N),
            .KW (KW),
            .P  (S.p),
            .R  (S.r),
            .D  (S.d)
        ) lvl_i (
            .clk    (clk),
            .keys_i (stage_keys[g]),
            .keys_o (stage_keys[g+1])
        );
    end

    msort_vpipe #(.DEPTH(L)) vpipe_i (
        .clk  (clk),
        .rst  (rst),
        .vin  (in_valid),
        .vout (out_valid)
    );

    assign out_keys = stage_keys[L];

endmodule

// File: rtl/msort_net_chk.sv
module msort_net_chk #(
    parameter int unsigned N  = 16,
    parameter int unsigned KW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [N*KW-1:0] in_keys,
    input  logic            out_valid,
    input  logic [N*KW-1:0] out_keys
);
    import msort_pkg::*;

    localparam int unsigned L  = num_levels(N);
    localparam int unsigned SW = KW + $clog2(N) + 1;

    function automatic logic is_ascending(input logic [N*KW-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int unsigned k = 1; k < N; k++) begin
            if (v[(k-1)*KW +: KW] > v[k*KW +: KW]) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic logic [SW-1:0] key_sum(input logic [N*KW-1:0] v);
        logic [SW-1:0] s;
        s = '0;
        for (int unsigned k = 0; k < N; k++) s = s + SW'(v[k*KW +: KW]);
        return s;
    endfunction

    logic [L-1:0]  vhist;
    logic [SW-1:0] shist [0:L-1];

    always_ff @(posedge clk) begin
        if (rst) vhist <= '0;
        else     vhist <= {vhist[L-2:0], in_valid};
        shist[0] <= key_sum(in_keys);
        for (int unsigned k = 1; k < L; k++) shist[k] <= shist[k-1];
    end

    // R1 / R7 / R9: valid results are ascending in unsigned order
    a_r1_ascending: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> is_ascending(out_keys));

    // R2: key multiset preserved (sum over the vector L cycles earlier)
    a_r2_sum_kept: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (key_sum(out_keys) == shist[L-1]));

    // R3 / R8: out_valid mirrors in_valid after exactly L cycles
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == vhist[L-1]);

    // R5: reset empties the valid pipeline by the next cycle
    a_r5_reset_clears: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind msort_net msort_net_chk #(.N(N), .KW(KW)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_keys   (in_keys),
    .out_valid (out_valid),
    .out_keys  (out_keys)
);

// File: tb/msort_net_tb.sv
module msort_net_tb_top;

    localparam int N     = 16;
    localparam int KW    = 8;
    localparam int LG    = $clog2(N);
    localparam int L     = LG * (LG + 1) / 2;
    localparam int TOTAL = 220;
    localparam int RSTC  = 90;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [N*KW-1:0] in_keys = '0;
    logic            out_valid;
    logic [N*KW-1:0] out_keys;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic            exp_v   [0:TOTAL-1];
    logic [N*KW-1:0] exp_k   [0:TOTAL-1];
    string           exp_tag [0:TOTAL-1];

    always #10 clk = ~clk;

    msort_net #(.N(N), .KW(KW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_keys   (in_keys),
        .out_valid (out_valid),
        .out_keys  (out_keys)
    );

    function automatic logic [N*KW-1:0] ref_sort(input logic [N*KW-1:0] v);
        logic [KW-1:0] a [N];
        logic [KW-1:0] t;
        logic [N*KW-1:0] o;
        for (int k = 0; k < N; k++) a[k] = v[k*KW +: KW];
        for (int x = 0; x < N; x++)
            for (int y = 0; y < N - 1 - x; y++)
                if (a[y] > a[y+1]) begin t = a[y]; a[y] = a[y+1]; a[y+1] = t; end
        for (int k = 0; k < N; k++) o[k*KW +: KW] = a[k];
        return o;
    endfunction

    task automatic check_out(input int cyc);
        int src;
        logic ev;
        string tg;
        src = cyc - L;
        ev  = (src >= 0) ? exp_v[src] : 1'b0;
        tg  = (src >= 0) ? exp_tag[src] : "R5";
        checks++;
        if (out_valid !== ev) begin
            fails++;
            $display("FAIL %s cycle %0d: out_valid=%b expected %b", tg, cyc, out_valid, ev);
        end
        if (ev) begin
            checks++;
            if (out_keys !== exp_k[src]) begin
                fails++;
                $display("FAIL %s cycle %0d: keys=%h expected %h", tg, cyc, out_keys, exp_k[src]);
            end
        end
    endtask

    initial begin
        logic [N*KW-1:0] v;
        logic vv;
        string tg;
        void'($urandom(32'd4242));
        for (int c = 0; c < TOTAL; c++) begin
            @(negedge clk);
            if (c >= 1) check_out(c);
            rst = (c < 2) || (c == RSTC);
            v   = '0;
            vv  = 1'b1;
            tg  = "R4";
            case (c)
                2: begin for (int k = 0; k < N; k++) v[k*KW +: KW] = 8'h5A; tg = "R6"; end
                3: begin for (int k = 0; k < N; k++) v[k*KW +: KW] = KW'(k * 3); tg = "R9"; end
                4: begin for (int k = 0; k < N; k++) v[k*KW +: KW] = KW'(200 - k * 7); tg = "R9"; end
                5: begin for (int k = 0; k < N; k++) v[k*KW +: KW] = (k % 2) ? 8'h00 : 8'hFF; tg = "R7"; end
                6: begin for (int k = 0; k < N; k++) v[k*KW +: KW] = KW'(8'h7F + (k % 3)); tg = "R7"; end
                7: begin v = '1; vv = 1'b0; tg = "R8"; end
                8: begin for (int k = 0; k < N; k++) v[k*KW +: KW] = KW'(k % 2); tg = "R6"; end
                default: begin
                    for (int k = 0; k < N; k++) v[k*KW +: KW] = KW'($urandom_range(0, 255));
                    vv = ($urandom_range(0, 9) < 8);
                    tg = vv ? "R2" : "R8";
                    if (c >= TOTAL - L - 2) begin vv = 1'b0; tg = "R3"; end
                end
            endcase
            if (c < 2) begin vv = 1'b0; tg = "R5"; end
            in_valid   = vv;
            in_keys    = v;
            exp_v[c]   = vv && !rst;
            exp_k[c]   = ref_sort(v);
            exp_tag[c] = tg;
            if (c == RSTC) begin
                for (int b = RSTC - L + 1; b <= RSTC; b++) begin
                    exp_v[b]   = 1'b0;
                    exp_tag[b] = "R5";
                end
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule